// File: doc/BRIEF.md
# SPI Master Transfer Engine

This block is a byte-wide SPI master. A producer pushes bytes into a 64-entry transmit queue, software loads a burst length and then sets a start flag. The engine drives the serial clock, shifts each byte out on the data-out line and samples the data-in line. It places each received byte into a 64-entry receive queue, and it raises a one-cycle completion pulse once the programmed number of bytes has been exchanged. Clock polarity, clock phase and bit order are selectable. One of four active-low chip selects is picked by a 2-bit field, and that line is either framed automatically around the burst or driven to a level that software chooses.

Four words are written through a small port selected by `reg_sel`: 0 global control, 1 transfer control, 2 queue control, 3 burst length. All of them can be read back on dedicated outputs, together with a status word that carries the fill level of each queue.

The engine is a state machine with four states. **IDLE** waits for a start request. **LOAD** fetches the next transmit byte. **SHIFT** produces sixteen serial clock edges for one byte. **FINISH** emits the completion pulse. The transitions are as follows. *launch*: IDLE to LOAD, on a start request when the burst length is non-zero. *empty launch*: IDLE to FINISH, on a start request when the length is zero. *fetched*: LOAD to SHIFT, always. *next byte*: SHIFT to LOAD, after the sixteenth edge when more bytes remain. *last byte*: SHIFT to FINISH, after the sixteenth edge of the final byte. *retire*: FINISH to IDLE. *abort*: any state to IDLE, on a soft reset.

Top module: `spi_xfer_engine`

## Requirements
- R1: After reset every chip select is high, the serial clock is low, all readback words read zero and no event output is asserted.
- R2: The start flag (bit 31 of the transfer control word) launches a burst only while both the enable bit (bit 0) and the master bit (bit 1) of the global word are set. Otherwise the flag stays pending and the serial clock does not move.
- R3: A burst exchanges exactly the number of bytes written to the burst length word. That word counts down by one as each byte completes, and it reads zero at the end.
- R4: When the burst ends, `xfer_done` is high for exactly one cycle, and the start flag reads zero from the following cycle on.
- R5: While no burst runs, the serial clock idles at the clock polarity bit (bit 1). With the phase bit (bit 0) clear, data-in is sampled on the first edge of each bit. With it set, data-in is sampled on the second edge. In both cases the received byte equals the byte the slave sent.
- R6: With bit 12 of the transfer control word clear, bits go out and come in most significant first. With it set, least significant first.
- R7: Bits [5:4] of the transfer control word select one chip select. While software does not own the line, the selected line is low only during a burst, and at most one line is ever low.
- R8: With the ownership bit (bit 6) set, the selected chip select follows the level bit (bit 7; 1 = high) whether or not a burst runs.
- R9: Each queue holds 64 bytes. The status word reports the transmit fill level in bits [23:16] and the receive fill level in bits [7:0].
- R10: Writing bit 31 (transmit) or bit 15 (receive) of the queue control word empties that queue. Each bit reads one for a single cycle and then clears itself.
- R11: If the transmit queue is empty when a byte is due, a zero byte is shifted out and `tx_underrun` pulses for one cycle.
- R12: If the receive queue is full when a byte completes, that byte is discarded, the queue is unchanged and `rx_overflow` pulses for one cycle.
- R13: Bit 31 of the global word requests a soft reset. It returns the engine to idle, empties both queues and clears the start flag, and it reads zero again one cycle later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Write strobe for the control words |
| reg_sel | input | 2 | Word select: 0 global, 1 transfer, 2 queue control, 3 burst length |
| reg_wdata | input | 32 | Write data |
| glb_word | output | 32 | Global control readback |
| xfer_word | output | 32 | Transfer control readback |
| fifo_word | output | 32 | Queue control readback |
| stat_word | output | 32 | Queue fill levels |
| burst_left | output | CNT_W | Bytes remaining in the burst |
| tx_push | input | 1 | Push a byte into the transmit queue |
| tx_data | input | 8 | Byte to push |
| rx_pop | input | 1 | Pop the head of the receive queue |
| rx_data | output | 8 | Head of the receive queue |
| sclk | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| cs_n | output | NCS | Active-low chip selects |
| xfer_done | output | 1 | Burst completion pulse |
| tx_underrun | output | 1 | Zero byte sent from an empty queue |
| rx_overflow | output | 1 | Received byte dropped on a full queue |

## Verification
Several properties are checked on every cycle: chip selects are never low on more than one line at once, the completion pulse lasts one cycle and clears the start flag, the burst length counts down one byte at a time, and the queue reset bits clear themselves. The checks also require that an underrun occurs only with an empty transmit queue, that an overflow occurs only with a full receive queue, and that a soft reset idles the engine, with the clock at its polarity level whenever the engine is idle. Only the bench's scenarios can show that the data is correct. A bench model of the slave exchanges bytes in every combination of polarity, phase and bit order. The same scenarios show the zero byte sent on underrun, the byte dropped on overflow, the blocking of a start while the engine is disabled, and the chip-select level under software ownership.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_LOAD,
        ST_SHIFT,
        ST_FINISH
    } eng_state_t;

    typedef struct packed {
        logic lsb_first;
        logic cpol;
        logic cpha;
    } spi_mode_t;

    // word select codes
    localparam logic [1:0] REG_GLB  = 2'd0;
    localparam logic [1:0] REG_XFER = 2'd1;
    localparam logic [1:0] REG_FIFO = 2'd2;
    localparam logic [1:0] REG_CNT  = 2'd3;

    // global word
    localparam int GC_EN   = 0;
    localparam int GC_MST  = 1;
    localparam int GC_SRST = 31;

    // transfer control word
    localparam int XC_CPHA   = 0;
    localparam int XC_CPOL   = 1;
    localparam int XC_SEL_LO = 4;
    localparam int XC_OWN    = 6;
    localparam int XC_LEVEL  = 7;
    localparam int XC_LSB    = 12;
    localparam int XC_START  = 31;

    // queue control word
    localparam int FC_RXRST = 15;
    localparam int FC_TXRST = 31;

endpackage

// File: rtl/spi_byte_fifo.sv
module spi_byte_fifo #(
    parameter int DEPTH = 64,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush,
    input  logic          push,
    input  logic [7:0]    din,
    input  logic          pop,
    output logic [7:0]    dout,
    output logic [CW-1:0] count,
    output logic          full,
    output logic          empty
);
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic [7:0]    mem [DEPTH];
    logic [AW-1:0] wp, rp;
    logic          do_push, do_pop;

    assign full    = (count == CW'(DEPTH));
    assign empty   = (count == '0);
    assign do_push = push && !full;
    assign do_pop  = pop && !empty;
    assign dout    = mem[rp];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else if (flush) begin
            wp    <= '0;
            rp    <= '0;
            count <= '0;
        end else begin
            if (do_push) wp <= (wp == AW'(DEPTH - 1)) ? '0 : wp + 1'b1;
            if (do_pop)  rp <= (rp == AW'(DEPTH - 1)) ? '0 : rp + 1'b1;
            count <= count + CW'(do_push) - CW'(do_pop);
        end
    end

    always_ff @(posedge clk) begin
        if (do_push && !flush) mem[wp] <= din;
    end

    // R9
    count_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        count <= CW'(DEPTH));

    // R12
    full_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (full && push && !pop && !flush) |=> (count == CW'(DEPTH)));

endmodule

// File: rtl/spi_shift_fsm.sv
module spi_shift_fsm
    import spi_eng_pkg::*;
#(
    parameter int HALF = 2
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      abort,
    input  logic      go_req,
    input  logic      cnt_zero,
    input  logic      cnt_last,
    input  spi_mode_t mode,
    input  logic      tx_empty,
    input  logic [7:0] tx_head,
    input  logic      rx_full,
    input  logic      miso,
    output logic      tx_pop,
    output logic      tx_udr,
    output logic      rx_push,
    output logic      rx_ovf,
    output logic [7:0] rx_byte,
    output logic      byte_done,
    output logic      done,
    output logic      busy,
    output logic      sclk,
    output logic      mosi
);
    localparam int HW = (HALF > 1) ? $clog2(HALF) : 1;

    eng_state_t    st, st_nx;
    logic [HW-1:0] hcnt;
    logic [3:0]    eidx;
    logic          lvl;
    logic [7:0]    tsh, rsh, rx_nx;
    logic          tick, lead, samp, shft, last_edge;

    assign tick      = (st == ST_SHIFT) && (hcnt == HW'(HALF - 1));
    assign lead      = !eidx[0];
    assign samp      = mode.cpha ? !lead : lead;
    assign shft      = mode.cpha ? (lead && (eidx != 4'd0)) : !lead;
    assign last_edge = tick && (eidx == 4'd15);

    always_comb begin
        rx_nx = rsh;
        if (tick && samp)
            rx_nx = mode.lsb_first ? {miso, rsh[7:1]} : {rsh[6:0], miso};
    end

    always_comb begin
        st_nx = st;
        unique case (st)
            ST_IDLE:   if (go_req) st_nx = cnt_zero ? ST_FINISH : ST_LOAD;
            ST_LOAD:   st_nx = ST_SHIFT;
            ST_SHIFT:  if (last_edge) st_nx = cnt_last ? ST_FINISH : ST_LOAD;
            ST_FINISH: st_nx = ST_IDLE;
        endcase
        if (abort) st_nx = ST_IDLE;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_IDLE;
        else        st <= st_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt <= '0;
            eidx <= '0;
            lvl  <= 1'b0;
            tsh  <= '0;
            rsh  <= '0;
        end else if (abort) begin
            hcnt <= '0;
            eidx <= '0;
            lvl  <= 1'b0;
        end else begin
            hcnt <= (st == ST_SHIFT && !tick) ? hcnt + 1'b1 : '0;
            rsh  <= rx_nx;
            if (st == ST_LOAD) begin
                eidx <= '0;
                lvl  <= 1'b0;
                tsh  <= tx_empty ? 8'h00 : tx_head;
            end else if (tick) begin
                eidx <= eidx + 1'b1;
                lvl  <= !lvl;
                if (shft) tsh <= mode.lsb_first ? {1'b0, tsh[7:1]} : {tsh[6:0], 1'b0};
            end
        end
    end

    always_comb begin
        tx_pop    = (st == ST_LOAD) && !tx_empty;
        tx_udr    = (st == ST_LOAD) && tx_empty;
        rx_push   = last_edge && !rx_full;
        rx_ovf    = last_edge && rx_full;
        rx_byte   = rx_nx;
        byte_done = last_edge;
        done      = (st == ST_FINISH);
        busy      = (st != ST_IDLE);
        sclk      = mode.cpol ^ lvl;
        mosi      = mode.lsb_first ? tsh[0] : tsh[7];
    end

    // R4
    done_once_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R5
    idle_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_IDLE) |-> (sclk == mode.cpol));

endmodule

// File: rtl/spi_xfer_engine.sv
module spi_xfer_engine
    import spi_eng_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int HALF  = 2,
    parameter int CNT_W = 16,
    parameter int NCS   = 4,
    localparam int SEL_W = (NCS > 1) ? $clog2(NCS) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_wr,
    input  logic [1:0]       reg_sel,
    input  logic [31:0]      reg_wdata,
    output logic [31:0]      glb_word,
    output logic [31:0]      xfer_word,
    output logic [31:0]      fifo_word,
    output logic [31:0]      stat_word,
    output logic [CNT_W-1:0] burst_left,
    input  logic             tx_push,
    input  logic [7:0]       tx_data,
    input  logic             rx_pop,
    output logic [7:0]       rx_data,
    output logic             sclk,
    output logic             mosi,
    input  logic             miso,
    output logic [NCS-1:0]   cs_n,
    output logic             xfer_done,
    output logic             tx_underrun,
    output logic             rx_overflow
);
    localparam int CW = $clog2(DEPTH + 1);

    logic             en_q, mst_q, srst_q;
    logic             start_q, lsb_q, lvl_q, own_q, cpol_q, cpha_q;
    logic [SEL_W-1:0] sel_q;
    logic             txrst_q, rxrst_q;
    logic [CNT_W-1:0] cnt_q;
    logic             glb_wr, xfer_wr, fifo_wr, cnt_wr;
    logic             busy, byte_done, tx_pop, rx_push;
    logic             tx_empty, tx_full, rx_empty, rx_full;
    logic [7:0]       tx_head, rx_byte;
    logic [CW-1:0]    tx_cnt, rx_cnt;
    spi_mode_t        mode;
    logic             wdata_unused;

    assign glb_wr  = reg_wr && (reg_sel == REG_GLB);
    assign xfer_wr = reg_wr && (reg_sel == REG_XFER);
    assign fifo_wr = reg_wr && (reg_sel == REG_FIFO);
    assign cnt_wr  = reg_wr && (reg_sel == REG_CNT);
    assign wdata_unused = ^{reg_wdata, tx_full, rx_empty};

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            en_q <= 1'b0; mst_q <= 1'b0; srst_q <= 1'b0;
            start_q <= 1'b0; lsb_q <= 1'b0; lvl_q <= 1'b0; own_q <= 1'b0;
            cpol_q <= 1'b0; cpha_q <= 1'b0; sel_q <= '0;
            txrst_q <= 1'b0; rxrst_q <= 1'b0; cnt_q <= '0;
        end else begin
            srst_q  <= glb_wr && reg_wdata[GC_SRST];
            txrst_q <= fifo_wr && reg_wdata[FC_TXRST];
            rxrst_q <= fifo_wr && reg_wdata[FC_RXRST];
            if (glb_wr) begin
                en_q  <= reg_wdata[GC_EN];
                mst_q <= reg_wdata[GC_MST];
            end
            if (xfer_wr) begin
                start_q <= reg_wdata[XC_START];
                lsb_q   <= reg_wdata[XC_LSB];
                lvl_q   <= reg_wdata[XC_LEVEL];
                own_q   <= reg_wdata[XC_OWN];
                sel_q   <= reg_wdata[XC_SEL_LO +: SEL_W];
                cpol_q  <= reg_wdata[XC_CPOL];
                cpha_q  <= reg_wdata[XC_CPHA];
            end
            if (srst_q || xfer_done) start_q <= 1'b0;
            if (cnt_wr)         cnt_q <= reg_wdata[CNT_W-1:0];
            else if (byte_done) cnt_q <= cnt_q - 1'b1;
        end
    end

    assign mode = '{lsb_first: lsb_q, cpol: cpol_q, cpha: cpha_q};

    spi_byte_fifo #(.DEPTH(DEPTH)) u_txq (
        .clk(clk), .rst_n(rst_n), .flush(txrst_q || srst_q),
        .push(tx_push), .din(tx_data), .pop(tx_pop), .dout(tx_head),
        .count(tx_cnt), .full(tx_full), .empty(tx_empty)
    );

    spi_byte_fifo #(.DEPTH(DEPTH)) u_rxq (
        .clk(clk), .rst_n(rst_n), .flush(rxrst_q || srst_q),
        .push(rx_push), .din(rx_byte), .pop(rx_pop), .dout(rx_data),
        .count(rx_cnt), .full(rx_full), .empty(rx_empty)
    );

    spi_shift_fsm #(.HALF(HALF)) u_fsm (
        .clk(clk), .rst_n(rst_n), .abort(srst_q),
        .go_req(start_q && en_q && mst_q && !srst_q),
        .cnt_zero(cnt_q == '0), .cnt_last(cnt_q == CNT_W'(1)),
        .mode(mode), .tx_empty(tx_empty), .tx_head(tx_head),
        .rx_full(rx_full), .miso(miso),
        .tx_pop(tx_pop), .tx_udr(tx_underrun), .rx_push(rx_push),
        .rx_ovf(rx_overflow), .rx_byte(rx_byte), .byte_done(byte_done),
        .done(xfer_done), .busy(busy), .sclk(sclk), .mosi(mosi)
    );

    for (genvar i = 0; i < NCS; i++) begin : g_cs
        assign cs_n[i] = (sel_q == SEL_W'(i)) ? (own_q ? lvl_q : !busy) : 1'b1;
    end

    always_comb begin
        glb_word = '0;
        glb_word[GC_EN]   = en_q;
        glb_word[GC_MST]  = mst_q;
        glb_word[GC_SRST] = srst_q;
        xfer_word = '0;
        xfer_word[XC_START] = start_q;
        xfer_word[XC_LSB]   = lsb_q;
        xfer_word[XC_LEVEL] = lvl_q;
        xfer_word[XC_OWN]   = own_q;
        xfer_word[XC_SEL_LO +: SEL_W] = sel_q;
        xfer_word[XC_CPOL]  = cpol_q;
        xfer_word[XC_CPHA]  = cpha_q;
        fifo_word = '0;
        fifo_word[FC_TXRST] = txrst_q;
        fifo_word[FC_RXRST] = rxrst_q;
        stat_word  = {8'd0, 8'(tx_cnt), 8'd0, 8'(rx_cnt)};
        burst_left = cnt_q;
    end

    // R7
    cs_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(~cs_n));

    // R4
    done_clears_start_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (xfer_done && !xfer_wr) |=> !xfer_word[XC_START]);

    // R3
    cnt_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (byte_done && !cnt_wr) |=> (burst_left == $past(burst_left) - 1'b1));

    // R10
    fifo_bit_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fifo_word[FC_TXRST] && !fifo_wr) |=> !fifo_word[FC_TXRST]);

    // R11
    udr_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tx_underrun |-> (tx_cnt == '0));

    // R12
    ovf_full_chk: assert property (@(posedge clk) disable iff (!rst_n)
        rx_overflow |-> (rx_cnt == CW'(DEPTH)));

    // R13
    srst_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        srst_q |=> (!busy && !start_q && !glb_word[GC_SRST]));

endmodule

// File: tb/sim_spi_xfer_engine.sv
module sim_spi_xfer_engine;
    localparam int DEPTH = 64;
    localparam int HALF  = 2;
    localparam int CNT_W = 16;
    localparam int NCS   = 4;

    // {cpol, cpha, lsb, sel[1:0], tx[7:0], slave byte[7:0]}
    localparam logic [20:0] VEC [0:5] = '{
        {1'b0, 1'b0, 1'b0, 2'd0, 8'hA5, 8'h3C},
        {1'b0, 1'b1, 1'b0, 2'd1, 8'h5A, 8'hC3},
        {1'b1, 1'b0, 1'b0, 2'd2, 8'h81, 8'h7E},
        {1'b1, 1'b1, 1'b0, 2'd3, 8'h0F, 8'hF0},
        {1'b0, 1'b0, 1'b1, 2'd1, 8'h96, 8'h6B},
        {1'b1, 1'b1, 1'b1, 2'd2, 8'h01, 8'h80}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic reg_wr = 1'b0;
    logic [1:0] reg_sel = '0;
    logic [31:0] reg_wdata = '0;
    logic [31:0] glb_word, xfer_word, fifo_word, stat_word;
    logic [CNT_W-1:0] burst_left;
    logic tx_push = 1'b0;
    logic [7:0] tx_data = '0;
    logic rx_pop = 1'b0;
    logic [7:0] rx_data;
    logic sclk, mosi;
    logic miso = 1'b0;
    logic [NCS-1:0] cs_n;
    logic xfer_done, tx_underrun, rx_overflow;

    always #5 clk = ~clk;

    spi_xfer_engine #(.DEPTH(DEPTH), .HALF(HALF), .CNT_W(CNT_W), .NCS(NCS)) u0 (
        .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
        .reg_wdata(reg_wdata), .glb_word(glb_word), .xfer_word(xfer_word),
        .fifo_word(fifo_word), .stat_word(stat_word), .burst_left(burst_left),
        .tx_push(tx_push), .tx_data(tx_data), .rx_pop(rx_pop), .rx_data(rx_data),
        .sclk(sclk), .mosi(mosi), .miso(miso), .cs_n(cs_n),
        .xfer_done(xfer_done), .tx_underrun(tx_underrun), .rx_overflow(rx_overflow)
    );

    int checks = 0, fails = 0, cyc = 0;
    int n_done = 0, n_udr = 0, n_ovf = 0;

    logic s_cpol = 1'b0, s_cpha = 1'b0, s_lsb = 1'b0, prev_sclk = 1'b0;
    logic [7:0] s_out [0:127];
    logic [7:0] s_cap [0:127];
    int out_pos = 0, samp_n = 0, lead_n = 0;

    task automatic summary();
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic logic slave_bit(input int pos);
        logic [7:0] b;
        int k;
        b = s_out[(pos / 8) % 128];
        k = pos % 8;
        return s_lsb ? b[k] : b[7 - k];
    endfunction

    task automatic tick();
        int k, bi;
        @(negedge clk);
        cyc++;
        if (cyc > 100000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected=<100000", cyc);
            summary();
            $finish;
        end
        n_done += int'(xfer_done);
        n_udr  += int'(tx_underrun);
        n_ovf  += int'(rx_overflow);
        if (sclk !== prev_sclk) begin
            if (sclk != s_cpol) begin
                lead_n++;
                if (!s_cpha) begin
                    k = samp_n % 8; bi = (samp_n / 8) % 128;
                    if (s_lsb) s_cap[bi][k] = mosi; else s_cap[bi][7 - k] = mosi;
                    samp_n++;
                end else if (lead_n > 1) out_pos++;
            end else begin
                if (!s_cpha) out_pos++;
                else begin
                    k = samp_n % 8; bi = (samp_n / 8) % 128;
                    if (s_lsb) s_cap[bi][k] = mosi; else s_cap[bi][7 - k] = mosi;
                    samp_n++;
                end
            end
        end
        prev_sclk = sclk;
        miso = slave_bit(out_pos);
    endtask

    task automatic slave_clear(input logic cpol, input logic cpha, input logic lsb);
        s_cpol = cpol; s_cpha = cpha; s_lsb = lsb;
        prev_sclk = sclk;
        out_pos = 0; samp_n = 0; lead_n = 0;
        miso = slave_bit(0);
    endtask

    task automatic reg_write(input logic [1:0] sel, input logic [31:0] d);
        reg_wr = 1'b1; reg_sel = sel; reg_wdata = d;
        tick();
        reg_wr = 1'b0;
    endtask

    task automatic push_tx(input logic [7:0] b);
        tx_push = 1'b1; tx_data = b;
        tick();
        tx_push = 1'b0;
    endtask

    task automatic pop_rx();
        rx_pop = 1'b1;
        tick();
        rx_pop = 1'b0;
    endtask

    task automatic fifo_clear();
        reg_write(2'd2, 32'h8000_8000);
        tick();
    endtask

    task automatic run_burst(input logic [31:0] cfg, input int nbytes, output logic [NCS-1:0] cs_seen);
        reg_write(2'd3, 32'(nbytes));
        reg_write(2'd1, cfg);
        slave_clear(cfg[1], cfg[0], cfg[12]);
        n_done = 0; n_udr = 0; n_ovf = 0;
        reg_write(2'd1, cfg | 32'h8000_0000);
        tick(); tick();
        cs_seen = cs_n;
        while (xfer_done !== 1'b1) tick();
        tick();
        // R4 one-cycle completion, start self-clears
        chk(xfer_done == 1'b0, "R4 done width", 32'(xfer_done), 32'd0);
        chk(xfer_word[31] == 1'b0, "R4 start cleared", xfer_word, 32'd0);
    endtask

    initial begin
        logic [NCS-1:0] cs_seen;
        logic [31:0] cfg;
        for (int i = 0; i < 128; i++) begin s_out[i] = 8'h00; s_cap[i] = 8'h00; end
        tick(); tick();
        rst_n = 1'b1;
        tick();

        // R1 reset state
        chk(cs_n == 4'hF, "R1 cs_n", 32'(cs_n), 32'hF);
        chk(sclk == 1'b0, "R1 sclk", 32'(sclk), 32'd0);
        chk(stat_word == 32'd0 && xfer_word == 32'd0 && glb_word == 32'd0 && fifo_word == 32'd0,
            "R1 readback", stat_word | xfer_word | glb_word, 32'd0);
        chk(!xfer_done && !tx_underrun && !rx_overflow, "R1 events",
            {29'd0, xfer_done, tx_underrun, rx_overflow}, 32'd0);

        // R2 enabled but not master: start stays pending
        reg_write(2'd0, 32'h1);
        reg_write(2'd3, 32'd1);
        push_tx(8'h11); push_tx(8'h22);
        n_done = 0;
        reg_write(2'd1, 32'h8000_0000);
        for (int i = 0; i < 30; i++) begin
            tick();
            if (sclk !== 1'b0) chk(1'b0, "R2 sclk moved", 32'(sclk), 32'd0);
        end
        chk(xfer_word[31] == 1'b1 && n_done == 0, "R2 pending start", xfer_word, 32'h8000_0000);
        // R9 transmit fill level in [23:16]
        chk(stat_word[23:16] == 8'd2, "R9 tx fill", stat_word, 32'h0002_0000);

        // R13 soft reset
        reg_write(2'd0, 32'h8000_0001);
        chk(glb_word[31] == 1'b1, "R13 srst visible", glb_word, 32'h8000_0001);
        tick();
        chk(glb_word[31] == 1'b0 && xfer_word[31] == 1'b0, "R13 srst clears start",
            {glb_word[31], xfer_word[30:0]}, 32'd0);
        chk(stat_word == 32'd0, "R13 queues emptied", stat_word, 32'd0);

        reg_write(2'd0, 32'h3);

        // R5 R6 R7 single-byte exchanges across modes
        foreach (VEC[i]) begin
            logic [20:0] v;
            v = VEC[i];
            fifo_clear();
            cfg = 32'(v[20]) << 1 | 32'(v[19]) | 32'(v[18]) << 12 | 32'(v[17:16]) << 4;
            push_tx(v[15:8]);
            s_out[0] = v[7:0];
            run_burst(cfg, 1, cs_seen);
            chk(cs_seen == ~(4'b1 << v[17:16]), "R7 auto cs", 32'(cs_seen), 32'(~(4'b1 << v[17:16])));
            chk(s_cap[0] == v[15:8], "R6 slave saw byte", 32'(s_cap[0]), 32'(v[15:8]));
            chk(rx_data == v[7:0] && stat_word[7:0] == 8'd1, "R5 received byte",
                32'(rx_data), 32'(v[7:0]));
            chk(sclk == v[20] && cs_n == 4'hF, "R5 idle clock level", 32'(sclk), 32'(v[20]));
            chk(n_done == 1, "R4 single pulse", 32'(n_done), 32'd1);
        end

        // R3 three-byte burst
        fifo_clear();
        push_tx(8'h11); push_tx(8'h22); push_tx(8'h33);
        s_out[0] = 8'hC1; s_out[1] = 8'hC2; s_out[2] = 8'hC3;
        run_burst(32'h0, 3, cs_seen);
        chk(s_cap[0] == 8'h11 && s_cap[1] == 8'h22 && s_cap[2] == 8'h33, "R3 tx bytes",
            {8'd0, s_cap[0], s_cap[1], s_cap[2]}, 32'h0011_2233);
        chk(stat_word[7:0] == 8'd3 && burst_left == '0, "R3 count", stat_word, 32'd3);
        chk(rx_data == 8'hC1, "R3 rx0", 32'(rx_data), 32'hC1);
        pop_rx();
        chk(rx_data == 8'hC2, "R3 rx1", 32'(rx_data), 32'hC2);
        pop_rx();
        chk(rx_data == 8'hC3, "R3 rx2", 32'(rx_data), 32'hC3);

        // R10 queue reset bits self-clear
        push_tx(8'h44);
        reg_write(2'd2, 32'h8000_8000);
        chk(fifo_word == 32'h8000_8000, "R10 bits set", fifo_word, 32'h8000_8000);
        tick();
        chk(fifo_word == 32'd0 && stat_word == 32'd0, "R10 cleared and empty",
            fifo_word | stat_word, 32'd0);

        // R11 underrun: two-byte burst with one byte queued
        push_tx(8'hA5);
        s_out[0] = 8'h00; s_out[1] = 8'h00;
        run_burst(32'h0, 2, cs_seen);
        chk(s_cap[0] == 8'hA5 && s_cap[1] == 8'h00, "R11 zero byte",
            {16'd0, s_cap[0], s_cap[1]}, 32'h0000_A500);
        chk(n_udr == 1, "R11 underrun pulse", 32'(n_udr), 32'd1);

        // R12 overflow: 65 bytes into a 64-entry receive queue
        fifo_clear();
        for (int i = 0; i < 64; i++) begin push_tx(8'(i + 1)); s_out[i] = 8'(8'hF0 ^ i); end
        s_out[64] = 8'h5E;
        run_burst(32'h0, 65, cs_seen);
        chk(stat_word[7:0] == 8'd64, "R12 rx held 64", stat_word, 32'd64);
        chk(n_ovf == 1 && n_udr == 1, "R12 overflow pulse", 32'(n_ovf), 32'd1);
        chk(rx_data == 8'hF0, "R12 head kept", 32'(rx_data), 32'hF0);

        // R8 software-owned chip select
        fifo_clear();
        reg_write(2'd1, 32'h0000_0060);
        tick();
        chk(cs_n == 4'b1011, "R8 own level low", 32'(cs_n), 32'hB);
        reg_write(2'd1, 32'h0000_00E0);
        tick();
        chk(cs_n == 4'hF, "R8 own level high", 32'(cs_n), 32'hF);

        summary();
        $finish;
    end
endmodule